// File: doc/BRIEF.md
# Fan Tachometer Period Counter with Coherent Byte Readout

The block measures the rotation period of a fan. It counts reference ticks between successive rising edges of the tachometer signal and keeps the result as a 16-bit period count. A larger count means a slower fan. The count saturates at 0xFFFF, so a stalled or very slow fan reads as all ones and never wraps back to a small value. A mode input divides the reference tick by four, which lets slow fans be measured without reaching saturation.

Software reads the count through a narrow byte port that holds two read-only registers, one for the high byte and one for the low byte. A read of the high byte also copies the matching low byte of the same count into a holding register. A later low-byte read returns that held value, so a high-then-low read pair gives one coherent 16-bit sample while the counter keeps updating. Read data appears one cycle after the read strobe and stays on the output until the next read.

Top module: `fan_tach_reader`

## Requirements
- R1: After reset, a high-byte read (`rd_sel_i`=0) returns 0x0F and a low-byte read (`rd_sel_i`=1) returns 0xFF.
- R2: The tach input passes through a two-flop synchronizer. Each synchronized rising edge stores the number of counting ticks seen since the previous rising edge, including a tick in the edge cycle itself, and restarts the count at zero.
- R3: The period count saturates at 0xFFFF and never wraps.
- R4: The count advances only on cycles where `ref_tick_i` is high. With no ticks, the stored period is 0.
- R5: With `slow_mode_i`=1, only every fourth reference tick advances the count. With `slow_mode_i`=0, every tick advances it.
- R6: `rd_sel_i`=0 selects the high byte (bits 15:8) and `rd_sel_i`=1 selects the low byte. Data is driven on `rd_data_o` the cycle after `rd_en_i` and held until the next read.
- R7: A high-byte read latches bits 7:0 of the same stored period into a holding register. Later captures do not change the held value.
- R8: A low-byte read returns the holding register. Low-byte reads with no high-byte read in between keep returning the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tach_i | input | 1 | Asynchronous tachometer input |
| ref_tick_i | input | 1 | Reference tick enable, one cycle per tick |
| slow_mode_i | input | 1 | 1: count every fourth tick (slow fans) |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 1 | Register select: 0 high byte, 1 low byte |
| rd_data_o | output | 8 | Read data, registered |

## Verification
On every cycle, the assertions check the following: the edge detector produces single-cycle pulses, the running count clears after an edge and otherwise never decreases, it holds at 0xFFFF, the divided tick never fires on two cycles in a row in slow mode, and the holding register changes only on a high-byte read, taking the low byte of the stored period. Only the bench scenarios can show the measured values. These are exact tick counts over sweeps of tach periods with dense, sparse and absent ticks in both modes, saturation after a long stall, and a high-then-low read pair that stays coherent across a change of period.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam logic [CNT_W-1:0]  PERIOD_RST = 16'h0FFF;
  localparam logic [BYTE_W-1:0] HOLD_RST   = 8'hFF;

  typedef enum logic {
    SEL_HI = 1'b0,
    SEL_LO = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tach_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tach_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R2: an edge produces a single-cycle pulse
  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic slow_i,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  generate
    if (DIV > 1) begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      div_q <= '0;
        else if (!slow_i) div_q <= '0;
        else if (tick_i)  div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
      end
      assign tick_o = slow_i ? (tick_i & (div_q == LAST)) : tick_i;

      // R5: in slow mode the divided tick cannot fire on two consecutive cycles
      p_slow_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slow_i && tick_o) |=> !(slow_i && tick_o));
    end else begin : g_pass
      assign tick_o = tick_i;
    end
  endgenerate

  // R4: a counting tick always comes from a reference tick
  always_comb begin
    if (rst_ni) p_tick_source_r4: assert (!tick_o || tick_i);
  end
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int unsigned           W       = 16,
  parameter logic [W-1:0]          RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_i,
  input  logic         tick_i,
  output logic [W-1:0] period_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] run_q, period_q, run_inc;

  assign run_inc = (run_q == MAX) ? MAX : run_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      period_q <= RST_VAL;
    end else if (rise_i) begin
      period_q <= tick_i ? run_inc : run_q;
      run_q    <= '0;
    end else if (tick_i) begin
      run_q <= run_inc;
    end
  end

  assign period_o = period_q;

  // R2: count restarts after an edge
  p_clear_on_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (run_q == '0));
  // R3: saturated count holds until an edge
  p_sat_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == MAX && !rise_i) |=> (run_q == MAX));
  // R3: no wrap, count never decreases between edges
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> (run_q >= $past(run_q)));
  // R4: no tick, no change
  p_idle_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && !tick_i) |=> $stable(run_q));
endmodule

// File: rtl/byte_readout.sv
module byte_readout
  import fan_tach_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [BYTE_W-1:0] hold_q, data_q;
  logic              rd_hi, rd_lo;

  assign rd_hi = rd_en_i && (rd_sel_i == SEL_HI);
  assign rd_lo = rd_en_i && (rd_sel_i == SEL_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= HOLD_RST;
      data_q <= '0;
    end else if (rd_hi) begin
      hold_q <= period_i[BYTE_W-1:0];
      data_q <= period_i[CNT_W-1:BYTE_W];
    end else if (rd_lo) begin
      data_q <= hold_q;
    end
  end

  assign rd_data_o = data_q;

  // R7: holding register changes only on a high-byte read
  p_hold_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hi |=> $stable(hold_q));
  // R7: high-byte read pairs the two halves of one sample
  p_hi_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi |=> ({rd_data_o, hold_q} == $past(period_i)));
  // R6: output held between reads
  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/fan_tach_reader.sv
module fan_tach_reader
  import fan_tach_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SLOW_DIV    = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tach_i,
  input  logic        ref_tick_i,
  input  logic        slow_mode_i,
  input  logic        rd_en_i,
  input  logic        rd_sel_i,
  output logic [7:0]  rd_data_o
);
  logic             rise;
  logic             cnt_tick;
  logic [CNT_W-1:0] period;

  tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tach_i (tach_i),
    .rise_o (rise)
  );

  tick_divider #(.DIV(SLOW_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ref_tick_i),
    .slow_i (slow_mode_i),
    .tick_o (cnt_tick)
  );

  period_counter #(.W(CNT_W), .RST_VAL(PERIOD_RST)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .tick_i   (cnt_tick),
    .period_o (period)
  );

  byte_readout u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .period_i  (period),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: tb/fan_tach_reader_test.sv
`timescale 1ns/1ps
module fan_tach_reader_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tach_i = 1'b0;
  logic       ref_tick_i = 1'b0;
  logic       slow_mode_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic       rd_sel_i = 1'b0;
  logic [7:0] rd_data_o;

  int total = 0;
  int bad = 0;
  int tick_mode = 0;   // 0 every cycle, 1 every other cycle, 2 none
  int cyc = 0;
  bit done = 1'b0;

  fan_tach_reader uut (.*);

  always #10 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    ref_tick_i <= (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? cyc[0] : 1'b0;
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(logic sel, output logic [7:0] val);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_sel_i = sel;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    val = rd_data_o;
  endtask

  task automatic wave(int p);
    tach_i = 1'b1;
    repeat (p / 2) @(negedge clk_i);
    tach_i = 1'b0;
    repeat (p - p / 2) @(negedge clk_i);
  endtask

  task automatic measure(string req, int p, int exp);
    logic [7:0] h, l;
    repeat (3) wave(p);
    rd(1'b0, h);
    rd(1'b1, l);
    check(req, h, 8'(exp >> 8));
    check(req, l, 8'(exp));
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset values, low first then high
    rd(1'b1, v); check("R1 lo", v, 8'hFF);
    rd(1'b0, v); check("R1 hi", v, 8'h0F);
    // R8 low read with no fresh high read keeps held value
    rd(1'b1, v); check("R8 lo", v, 8'hF0 ^ 8'h0F);

    // R2 R6 fast mode, tick every cycle
    tick_mode = 0; slow_mode_i = 1'b0;
    for (int k = 0; k < 11; k++) measure("R2", 6 + k * 97, 6 + k * 97);

    // R4 sparse ticks: half the cycles
    tick_mode = 1;
    for (int k = 0; k < 6; k++) measure("R4 sparse", 20 + k * 130, (20 + k * 130) / 2);

    // R4 no ticks
    tick_mode = 2;
    measure("R4 none", 50, 0);

    // R5 slow mode
    slow_mode_i = 1'b1; tick_mode = 0;
    for (int k = 1; k < 8; k++) measure("R5 slow", k * 164, k * 41);
    tick_mode = 1;
    for (int k = 1; k < 5; k++) measure("R5 slow sparse", k * 240, k * 30);
    slow_mode_i = 1'b0; tick_mode = 0;

    // R7 coherence across a period change: 300 = 0x012C, 592 = 0x0250
    repeat (3) wave(300);
    rd(1'b0, v); check("R7 hi", v, 8'h01);
    repeat (3) wave(592);
    rd(1'b1, v); check("R7 lo held", v, 8'h2C);
    rd(1'b1, v); check("R8 lo repeat", v, 8'h2C);
    rd(1'b0, v); check("R7 hi new", v, 8'h02);
    rd(1'b1, v); check("R7 lo new", v, 8'h50);

    // R6 output holds with no read
    repeat (20) @(negedge clk_i);
    check("R6 hold", rd_data_o, 8'h50);

    // R3 saturation after a long stall
    repeat (70000) @(negedge clk_i);
    wave(100);
    rd(1'b0, v); check("R3 hi", v, 8'hFF);
    rd(1'b1, v); check("R3 lo", v, 8'hFF);
    measure("R3 recover", 100, 100);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule